// File: doc/BRIEF.md
# Frame Sync Acquisition and Monitor

This block locks the frame timing of a time-slot switch to an external sync pulse and then keeps checking that the pulse goes on arriving with the right spacing. The pulse is taken on the falling edge of the device clock. A rising edge of the sampled pulse moves the internal frame position counter back to zero. After that the counter free-runs and wraps once per programmed frame length. The frame length is a cycle count on an input port, so one design serves 512, 1024 or 2048 clock cycles per 125 µs frame, and also any other length of two or more.

A small tracker moves through three states: hunting, checking and locked. Two pulses spaced exactly one frame apart give lock. Once locked, a pulse at any other position ends lock. Two frame boundaries in a row with no pulse also end lock, so a single missing pulse is tolerated. Gaining lock and losing lock each set a sticky interrupt flag. Each flag stays set until its bit is written with one on the clear input. The lock status output follows the tracker state at all times.

Top module: `fsync_monitor`

## Requirements
- R1: While reset is asserted and directly after its release, `frame_pos` is 0, `sync_locked` is 0 and both interrupt flags are 0.
- R2: `sync_in` is sampled only on the falling clock edge. A high level that starts after one falling edge and ends before the next one has no effect on `frame_pos`.
- R3: Only a low-to-high change of the sampled pulse aligns the counter. `frame_pos` reads 0 on the rising clock edge after that sample and then counts up by one per cycle. A pulse held high causes only one alignment.
- R4: With no pulse arriving, `frame_pos` counts 0 up to `frame_len`-1 and then wraps to 0.
- R5: A pulse that arrives while `frame_pos` equals `frame_len`-1, after an earlier aligning pulse in the checking state, sets `sync_locked` and `irq_gained`.
- R6: While checking, a pulse at any other position does not give lock. It becomes the new reference, so a pulse exactly one frame after it then gives lock.
- R7: While locked, a pulse whose position is not `frame_len`-1 clears `sync_locked` and sets `irq_lost`.
- R8: While locked, one frame boundary without a pulse keeps lock. A second boundary in a row without a pulse clears `sync_locked` and sets `irq_lost` on that boundary edge.
- R9: Both interrupt flags are sticky. `irq_clr` bit 0 clears `irq_gained` and bit 1 clears `irq_lost`. A set event in the same cycle as a clear wins.
- R10: The frame length is taken from `frame_len` at run time. The same behaviour holds for different lengths without rebuilding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | External frame sync pulse |
| frame_len | input | LEN_W | Frame length in clock cycles (two or more) |
| irq_clr | input | 2 | Write-one-to-clear: bit 0 gained, bit 1 lost |
| frame_pos | output | LEN_W | Aligned cycle position within the frame |
| sync_locked | output | 1 | High while synchronised |
| irq_gained | output | 1 | Sticky flag: lock achieved |
| irq_lost | output | 1 | Sticky flag: lock lost |

## Verification
The bench builds the block with the default `LEN_W` of 12, which covers the 2048-cycle frame of the fastest clock rate. It drives `frame_len` at run time with short lengths of 16 and 24, so many frames fit into a short run. One lock sequence also runs at 512 cycles, the real frame length at the slowest rate. The short lengths make it possible to test many cases: early and late pulses, single and double misses, re-acquisition after loss, and a clear that lands in the same cycle as a set. A glitch placed between two falling edges shows that the pulse is really taken on the falling edge.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_CHECK  = 2'd1,
    ST_LOCKED = 2'd2
  } sync_state_e;

  localparam int IRQ_GAIN = 0;
  localparam int IRQ_LOST = 1;
  localparam int IRQ_N    = 2;
endpackage

// File: rtl/fsync_sampler.sv
module fsync_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_in,
  output logic rise_o
);
  logic fall_smp;
  logic prev_smp;

  // pulse is captured on the falling clock edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_smp <= 1'b0;
    else        fall_smp <= sync_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_smp <= 1'b0;
    else        prev_smp <= fall_smp;
  end

  assign rise_o = fall_smp & ~prev_smp;

  AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o); // R3
endmodule

// File: rtl/fsync_frame_ctr.sv
module fsync_frame_ctr #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             align_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] pos_o,
  output logic             at_end_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  function automatic logic [LEN_W-1:0] last_pos(input logic [LEN_W-1:0] len);
    return len - ONE;
  endfunction

  function automatic logic [LEN_W-1:0] step_pos(input logic [LEN_W-1:0] pos,
                                                input logic [LEN_W-1:0] len);
    return (pos == last_pos(len)) ? '0 : pos + ONE;
  endfunction

  logic [LEN_W-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pos_q <= '0;
    else if (align_i) pos_q <= '0;
    else              pos_q <= step_pos(pos_q, len_i);
  end

  assign pos_o    = pos_q;
  assign at_end_o = (pos_q == last_pos(len_i));

  AST_ALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    align_i |=> (pos_o == '0)); // R3
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (len_i > ONE) |-> (pos_o < len_i)); // R4
endmodule

// File: rtl/fsync_tracker.sv
module fsync_tracker
  import fsync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,
  input  logic at_end_i,
  output logic locked_o,
  output logic gain_o,
  output logic lost_o
);
  sync_state_e st_q, st_d;
  logic        miss_q, miss_d;
  logic        on_time;
  logic        no_pulse_end;

  assign on_time      = rise_i & at_end_i;
  assign no_pulse_end = at_end_i & ~rise_i;

  always_comb begin
    st_d   = st_q;
    miss_d = miss_q;
    gain_o = 1'b0;
    lost_o = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        miss_d = 1'b0;
        if (rise_i) st_d = ST_CHECK;
      end
      ST_CHECK: begin
        miss_d = 1'b0;
        if (on_time) begin
          st_d   = ST_LOCKED;
          gain_o = 1'b1;
        end else if (no_pulse_end) begin
          st_d = ST_HUNT;
        end
      end
      ST_LOCKED: begin
        if (rise_i) begin
          miss_d = 1'b0;
          if (!at_end_i) begin
            st_d   = ST_CHECK;
            lost_o = 1'b1;
          end
        end else if (at_end_i) begin
          if (miss_q) begin
            st_d   = ST_HUNT;
            miss_d = 1'b0;
            lost_o = 1'b1;
          end else begin
            miss_d = 1'b1;
          end
        end
      end
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HUNT;
      miss_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      miss_q <= miss_d;
    end
  end

  assign locked_o = (st_q == ST_LOCKED);

  AST_LOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(rise_i && at_end_i)); // R5
  AST_LOSS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_o) |-> $past(lost_o)); // R7
  AST_NO_GAIN_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    !(gain_o && lost_o)); // R5
endmodule

// File: rtl/fsync_irq.sv
module fsync_irq
  import fsync_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_N-1:0] set_i,
  input  logic [IRQ_N-1:0] clr_i,
  output logic [IRQ_N-1:0] flag_o
);
  for (genvar g = 0; g < IRQ_N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (set_i[g])  flag_q <= 1'b1;
      else if (clr_i[g])  flag_q <= 1'b0;
    end
    assign flag_o[g] = flag_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> flag_o[g]); // R9
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[g] && !clr_i[g]) |=> flag_o[g]); // R9
  end
endmodule

// File: rtl/fsync_monitor.sv
module fsync_monitor
  import fsync_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [1:0]       irq_clr,
  output logic [LEN_W-1:0] frame_pos,
  output logic             sync_locked,
  output logic             irq_gained,
  output logic             irq_lost
);
  logic             sp_rise;
  logic             frame_end;
  logic             ev_gain;
  logic             ev_lost;
  logic [IRQ_N-1:0] irq_set;
  logic [IRQ_N-1:0] irq_flags;

  fsync_sampler u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_in (sync_in),
    .rise_o  (sp_rise)
  );

  fsync_frame_ctr #(.LEN_W(LEN_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .align_i  (sp_rise),
    .len_i    (frame_len),
    .pos_o    (frame_pos),
    .at_end_o (frame_end)
  );

  fsync_tracker u_trk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_i   (sp_rise),
    .at_end_i (frame_end),
    .locked_o (sync_locked),
    .gain_o   (ev_gain),
    .lost_o   (ev_lost)
  );

  always_comb begin
    irq_set           = '0;
    irq_set[IRQ_GAIN] = ev_gain;
    irq_set[IRQ_LOST] = ev_lost;
  end

  fsync_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (irq_set),
    .clr_i  (irq_clr),
    .flag_o (irq_flags)
  );

  assign irq_gained = irq_flags[IRQ_GAIN];
  assign irq_lost   = irq_flags[IRQ_LOST];

  AST_GAIN_WITH_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_locked) |-> irq_gained); // R5
  AST_LOST_WITH_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_locked) |-> irq_lost); // R7
endmodule

// File: tb/tb_fsync_monitor.sv
`timescale 1ns/1ps
module tb_fsync_monitor;
  localparam int CLK_P = 10;
  localparam int LW    = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sync_in = 1'b0;
  logic [LW-1:0] frame_len = LW'(16);
  logic [1:0]    irq_clr = 2'b00;
  logic [LW-1:0] frame_pos;
  logic          sync_locked, irq_gained, irq_lost;

  int n_run = 0, n_fail = 0;
  int flen = 16;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fsync_monitor #(.LEN_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .frame_len(frame_len),
    .irq_clr(irq_clr), .frame_pos(frame_pos), .sync_locked(sync_locked),
    .irq_gained(irq_gained), .irq_lost(irq_lost)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int len);
    flen = len;
    rst_n = 1'b0; sync_in = 1'b0; irq_clr = 2'b00;
    frame_len = LW'(len);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // raise just after an edge; sampled on the falling edge, acts on the next rising edge
  task automatic pulse();
    sync_in = 1'b1;
    @(posedge clk); #1 sync_in = 1'b0;
  endtask

  task automatic lock_up();
    pulse(); cyc(flen - 1); pulse();
  endtask

  task automatic t_reset();
    do_reset(16);
    chk("R1 pos", int'(frame_pos), 0);
    chk("R1 locked", int'(sync_locked), 0);
    chk("R1 gained", int'(irq_gained), 0);
    chk("R1 lost", int'(irq_lost), 0);
  endtask

  task automatic t_wrap();
    do_reset(16);
    pulse();
    chk("R3 align", int'(frame_pos), 0);
    cyc(15);
    chk("R4 last", int'(frame_pos), 15);
    cyc(1);
    chk("R4 wrap", int'(frame_pos), 0);
  endtask

  task automatic t_fall_sample();
    do_reset(16);
    pulse();
    cyc(1);
    #5 sync_in = 1'b1;   // after the falling edge
    #8 sync_in = 1'b0;   // before the next falling edge
    @(posedge clk); #1;
    chk("R2 glitch ignored", int'(frame_pos), 3);
    chk("R2 no lock", int'(sync_locked), 0);
  endtask

  task automatic t_held_high();
    do_reset(16);
    cyc(2);
    sync_in = 1'b1;
    cyc(1);
    chk("R3 first align", int'(frame_pos), 0);
    cyc(5);
    chk("R3 held no realign", int'(frame_pos), 5);
    sync_in = 1'b0;
  endtask

  task automatic t_gain(input int len);
    do_reset(len);
    pulse();
    cyc(flen - 1);
    chk("R5 before second", int'(sync_locked), 0);
    pulse();
    chk("R5 locked", int'(sync_locked), 1);
    chk("R5 gained irq", int'(irq_gained), 1);
    chk("R10 no lost", int'(irq_lost), 0);
  endtask

  task automatic t_bad_spacing();
    do_reset(16);
    pulse(); cyc(flen + 2); pulse();
    chk("R6 late no lock", int'(sync_locked), 0);
    chk("R6 no gain irq", int'(irq_gained), 0);
    chk("R6 realigned", int'(frame_pos), 0);
    cyc(flen - 1); pulse();
    chk("R6 lock from new ref", int'(sync_locked), 1);
  endtask

  task automatic t_early_loss();
    do_reset(16);
    lock_up();
    cyc(flen - 4); pulse();
    chk("R7 unlocked", int'(sync_locked), 0);
    chk("R7 lost irq", int'(irq_lost), 1);
    irq_clr = 2'b10; cyc(1); irq_clr = 2'b00;
    chk("R9 lost cleared", int'(irq_lost), 0);
    chk("R9 gained kept", int'(irq_gained), 1);
    // clear gained while a new gain event lands on the same edge
    irq_clr = 2'b01;
    cyc(flen - 2);
    chk("R9 gained cleared", int'(irq_gained), 0);
    pulse();
    irq_clr = 2'b00;
    chk("R9 set wins", int'(irq_gained), 1);
    chk("R6 relocked", int'(sync_locked), 1);
  endtask

  task automatic t_late_loss();
    do_reset(24);
    lock_up();
    cyc(flen + 2); pulse();
    chk("R7 late unlock", int'(sync_locked), 0);
    chk("R7 late lost irq", int'(irq_lost), 1);
  endtask

  task automatic t_miss();
    do_reset(16);
    lock_up();
    cyc(2 * flen - 1); pulse();
    chk("R8 one miss kept", int'(sync_locked), 1);
    chk("R8 no lost irq", int'(irq_lost), 0);
    cyc(2 * flen - 1);
    chk("R8 still locked", int'(sync_locked), 1);
    cyc(1);
    chk("R8 two misses unlock", int'(sync_locked), 0);
    chk("R8 lost irq", int'(irq_lost), 1);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_wrap();
    t_fall_sample();
    t_held_high();
    t_gain(16);
    t_gain(24);   // R10
    t_gain(512);  // R10
    t_bad_spacing();
    t_early_loss();
    t_late_loss();
    t_miss();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule